// File: doc/BRIEF.md
# Bitstream Window Extractor

This unit sits between a word-wide source of compressed data and a parser. It keeps a sliding window of buffered stream bits and always shows the consumer the bits that come next. The consumer picks a width, reads that many upcoming bits right-aligned on the peek output, and decides what to do with them before any of them are used up.

A separate advance request then moves the read position forward. A field advance consumes 0 to 32 bits. An align advance skips forward to the next byte boundary of the stream. Both advances finish in one clock cycle once enough bits are buffered. Refilling from the input is built from shifts and ORs only, so a word accepted in the same cycle as an advance lands directly behind the bits that remain.

Top module: `bwx_window`

## Requirements
- R1: `peek_bits` carries the next `peek_len` (0 to 32) unread bits right-aligned. Bit 0 is the last bit of that field, and every bit at position `peek_len` or above is zero. Peeking consumes nothing, so with no advance the output holds its value.
- R2: A field advance (`adv_valid`=1, `adv_align`=0) with `adv_len` from 0 to 32 consumes exactly `adv_len` bits in the cycle it is taken (`adv_valid` and `adv_ready` both high). The next peek starts right after those bits.
- R3: Stream order is the order in which words are accepted. Inside a word, bit 31 is the earliest stream bit and bit 0 the latest.
- R4: A word is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever at most 32 bits would remain after this cycle's advance. As a result, back-to-back 32-bit advances with input always offered never stall.
- R5: An align advance (`adv_align`=1) ignores `adv_len`. It moves the read position to the next multiple of 8 stream bits, consumes nothing when the position is already a multiple of 8, and is never stalled.
- R6: When a field advance asks for more bits than are buffered, `adv_ready` stays low and nothing is consumed. `adv_ready` rises once enough bits have arrived.
- R7: The window holds at most 64 bits. With no advance the buffer fills and `in_ready` then drops.
- R8: `peek_valid` is high exactly when at least `peek_len` bits are buffered.
- R9: After reset the window is empty: `in_ready` is high, and for a non-zero length both `peek_valid` and `adv_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_word | input | 32 | Next stream word, earliest bit in bit 31 |
| in_valid | input | 1 | `in_word` is offered |
| in_ready | output | 1 | Window can take a word this cycle |
| peek_len | input | 6 | Number of bits to show (0 to 32) |
| peek_bits | output | 32 | Upcoming bits, right-aligned |
| peek_valid | output | 1 | At least `peek_len` bits are buffered |
| adv_valid | input | 1 | Advance request |
| adv_len | input | 6 | Bits to consume for a field advance (0 to 32) |
| adv_align | input | 1 | Skip to the next byte boundary instead |
| adv_ready | output | 1 | The requested advance is taken this cycle |

## Verification
The hardest case to reach from the ports is a stall: a field advance must find fewer buffered bits than it asks for. Otherwise the window tops itself up as soon as it has room. The bench tracks the buffered bit count from the words it has delivered and the bits it has consumed. It turns the input off, consumes down to exactly 10 buffered bits, and then asks for 24 bits. It holds that request for several cycles to confirm nothing moves, then turns the input back on. Align advances are checked both from an odd position and from a position that is already on a byte boundary.

// File: rtl/bwx_pkg.sv
// Shared definitions for the bitstream window extractor.
// Assumes the input word width is a multiple of 8, so the buffered bit
// count modulo 8 equals the distance to the next stream byte boundary.
package bwx_pkg;

    // Kind of advance requested by the consumer.
    typedef enum logic {
        ADV_FIELD = 1'b0,
        ADV_ALIGN = 1'b1
    } adv_kind_e;

    // Bits to skip to reach a byte boundary, given the buffered count.
    function automatic logic [2:0] byte_slack(input logic [2:0] fill_low);
        return fill_low;
    endfunction

endpackage

// File: rtl/bwx_adv_ctl.sv
// Advance and refill control.
// Decides how many bits leave the window this cycle and whether an input
// word may enter. Assumes WORD_W is a multiple of 8 and BUF_W >= 2*WORD_W.
module bwx_adv_ctl
    import bwx_pkg::*;
#(
    parameter int BUF_W  = 64,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 7,
    parameter int LEN_W  = 6
) (
    input  logic [CNT_W-1:0] fill,
    input  logic             adv_valid,
    input  logic [LEN_W-1:0] adv_len,
    input  logic             adv_align,
    input  logic             in_valid,
    output logic             adv_ready,
    output logic             adv_fire,
    output logic [CNT_W-1:0] amt,
    output logic             in_ready,
    output logic             push
);
    localparam logic [CNT_W-1:0] ROOM = CNT_W'(BUF_W - WORD_W);

    adv_kind_e        kind;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] left;

    // Bits the pending request needs: the field length or the byte slack.
    always_comb begin
        kind = adv_kind_e'(adv_align);
        if (kind == ADV_ALIGN) need = CNT_W'(byte_slack(fill[2:0]));
        else                   need = CNT_W'(adv_len);
    end

    // Advance handshake: taken only when enough bits are buffered.
    always_comb begin
        adv_ready = (fill >= need);
        adv_fire  = adv_valid && adv_ready;
        amt       = adv_fire ? need : '0;
    end

    // Input handshake: accept when the remainder leaves room for a word.
    always_comb begin
        left     = fill - amt;
        in_ready = (left <= ROOM);
        push     = in_valid && in_ready;
    end

endmodule

// File: rtl/bwx_store.sv
// Window storage.
// Keeps the unread bits left-aligned (MSB is the next bit) and all bits
// beyond the buffered count at zero, so a new word can be ORed in place.
module bwx_store #(
    parameter int BUF_W  = 64,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  amt,
    input  logic              push,
    input  logic [WORD_W-1:0] in_word,
    output logic [BUF_W-1:0]  win,
    output logic [CNT_W-1:0]  fill
);
    localparam int PAD_W = BUF_W - WORD_W;

    logic [BUF_W-1:0] kept;
    logic [BUF_W-1:0] placed;
    logic [CNT_W-1:0] remain;
    logic [BUF_W-1:0] win_nx;
    logic [CNT_W-1:0] fill_nx;

    // Shift out consumed bits and OR the new word behind the remainder.
    always_comb begin
        kept    = win << amt;
        remain  = fill - amt;
        placed  = {in_word, {PAD_W{1'b0}}} >> remain;
        win_nx  = push ? (kept | placed) : kept;
        fill_nx = push ? remain + CNT_W'(WORD_W) : remain;
    end

    // Register the window and its bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win  <= '0;
            fill <= '0;
        end else begin
            win  <= win_nx;
            fill <= fill_nx;
        end
    end

    assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(BUF_W));

endmodule

// File: rtl/bwx_peek.sv
// Right-aligned peek of the next bits.
// Assumes peek_len never exceeds OUT_W.
module bwx_peek #(
    parameter int BUF_W = 64,
    parameter int OUT_W = 32,
    parameter int CNT_W = 7,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUF_W-1:0] win,
    input  logic [CNT_W-1:0] fill,
    input  logic [LEN_W-1:0] peek_len,
    output logic [OUT_W-1:0] peek_bits,
    output logic             peek_valid
);
    logic [CNT_W-1:0] shamt;
    logic [BUF_W-1:0] shifted;

    // Move the top peek_len bits down to bit 0; the rest shifts out.
    always_comb begin
        shamt      = CNT_W'(BUF_W) - CNT_W'(peek_len);
        shifted    = win >> shamt;
        peek_bits  = shifted[OUT_W-1:0];
        peek_valid = (fill >= CNT_W'(peek_len));
    end

    assert_peek_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_len < LEN_W'(OUT_W)) |-> ((peek_bits >> peek_len) == '0));

endmodule

// File: rtl/bwx_window.sv
// Bitstream window extractor top.
// Accepts stream words, shows the next bits right-aligned, and consumes a
// field length or skips to a byte boundary on request, one per cycle.
module bwx_window #(
    parameter int WORD_W = 32,
    parameter int BUF_W  = 64,
    parameter int PEEK_W = 32,
    parameter int CNT_W  = $clog2(BUF_W + 1),
    parameter int LEN_W  = $clog2(PEEK_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LEN_W-1:0]  peek_len,
    output logic [PEEK_W-1:0] peek_bits,
    output logic              peek_valid,
    input  logic              adv_valid,
    input  logic [LEN_W-1:0]  adv_len,
    input  logic              adv_align,
    output logic              adv_ready
);
    logic [BUF_W-1:0] win;
    logic [CNT_W-1:0] fill;
    logic [CNT_W-1:0] amt;
    logic             adv_fire;
    logic             push;

    bwx_adv_ctl #(.BUF_W(BUF_W), .WORD_W(WORD_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) i_ctl (
        .fill(fill), .adv_valid(adv_valid), .adv_len(adv_len), .adv_align(adv_align),
        .in_valid(in_valid), .adv_ready(adv_ready), .adv_fire(adv_fire), .amt(amt),
        .in_ready(in_ready), .push(push)
    );

    bwx_store #(.BUF_W(BUF_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) i_store (
        .clk(clk), .rst_n(rst_n), .amt(amt), .push(push), .in_word(in_word),
        .win(win), .fill(fill)
    );

    bwx_peek #(.BUF_W(BUF_W), .OUT_W(PEEK_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) i_peek (
        .clk(clk), .rst_n(rst_n), .win(win), .fill(fill), .peek_len(peek_len),
        .peek_bits(peek_bits), .peek_valid(peek_valid)
    );

    // Buffered count follows the handshakes of the previous cycle.
    assert_fill_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fill == $past(fill) - $past(amt)
                          + ($past(push) ? CNT_W'(WORD_W) : CNT_W'(0))));

    // After an align skip the read position sits on a byte boundary.
    assert_align_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(adv_fire && adv_align)) |-> (fill[2:0] == 3'd0));

    // Peeking alone never changes the visible bits.
    assert_peek_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(adv_fire) && $past(peek_valid) && $stable(peek_len))
            |-> $stable(peek_bits));

endmodule

// File: tb/test_bwx_window.sv
module test_bwx_window;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [5:0]  peek_len = '0;
    logic [31:0] peek_bits;
    logic        peek_valid;
    logic        adv_valid = 1'b0;
    logic [5:0]  adv_len = '0;
    logic        adv_align = 1'b0;
    logic        adv_ready;

    int          n_checks = 0;
    int          n_fail = 0;
    int          wcount = 0;
    longint      bitptr = 0;
    bit          feed_en = 1'b0;
    int          last_stalls = 0;
    bit          finished = 1'b0;
    logic [31:0] exp_q[$];

    bwx_window i_bwx_window (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .in_ready(in_ready), .peek_len(peek_len), .peek_bits(peek_bits),
        .peek_valid(peek_valid), .adv_valid(adv_valid), .adv_len(adv_len),
        .adv_align(adv_align), .adv_ready(adv_ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] word_at(input int k);
        logic [31:0] v;
        v = 32'(k + 1) * 32'h9E37_79B1;
        return v ^ {v[15:0], v[31:16]} ^ 32'hA5C3_0F96;
    endfunction

    function automatic logic [31:0] field_at(input longint ptr, input int len);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < len; i++) begin
            longint p;
            logic [31:0] w;
            p = ptr + i;
            w = word_at(int'(p / 32));
            v = (v << 1) | 32'(w[31 - int'(p % 32)]);
        end
        return v;
    endfunction

    function automatic int fill_model();
        return int'(longint'(wcount) * 32 - bitptr);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Feeder: offers the next stream word whenever enabled.
    always @(negedge clk) begin
        in_valid <= feed_en;
        in_word  <= word_at(wcount);
    end

    always @(posedge clk) begin
        if (rst_n && in_valid && in_ready) wcount <= wcount + 1;
    end

    // Monitor: pops the expected field for every field advance taken.
    always @(negedge clk) begin
        #2;
        if (rst_n && adv_valid && adv_ready && !adv_align) begin
            logic [31:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
            check(peek_bits == e, "R2 field value", peek_bits, e);
            check(peek_valid == 1'b1, "R8 valid at advance", peek_valid, 1);
        end
    end

    // Driver: requests one advance and records the expected field.
    task automatic take(input int len, input bit align);
        @(negedge clk);
        adv_len   = 6'(len);
        adv_align = align;
        peek_len  = align ? 6'd0 : 6'(len);
        adv_valid = 1'b1;
        #1;
        last_stalls = 0;
        while (!adv_ready) begin
            last_stalls++;
            @(negedge clk);
            #1;
        end
        if (!align) exp_q.push_back(field_at(bitptr, len));
        @(posedge clk);
        if (align) bitptr = (bitptr + 7) & ~longint'(7);
        else       bitptr = bitptr + len;
        #1;
        adv_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int stall_sum;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        peek_len = 6'd1;
        adv_len = 6'd1;
        #1;
        // R9: empty after reset
        check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
        check(peek_valid == 1'b0, "R9 peek_valid", peek_valid, 0);
        check(adv_ready == 1'b0, "R9 adv_ready", adv_ready, 0);

        // R1 / R3: peek without consuming
        feed_en = 1'b1;
        peek_len = 6'd20;
        repeat (4) @(negedge clk);
        #1;
        check(peek_valid == 1'b1, "R8 valid", peek_valid, 1);
        check(peek_bits == field_at(0, 20), "R3 first bits", peek_bits, field_at(0, 20));
        repeat (3) @(negedge clk);
        #1;
        check(peek_bits == field_at(0, 20), "R1 peek holds", peek_bits, field_at(0, 20));
        peek_len = 6'd32;
        #1;
        check(peek_bits == field_at(0, 32), "R1 full width", peek_bits, field_at(0, 32));

        // R2: assorted field lengths, zero included
        for (int i = 0; i < 40; i++) take((i * 7 + 3) % 33, 1'b0);

        // R5: align from an odd position, then from an aligned one
        take(5, 1'b0);
        take(0, 1'b1);
        check(last_stalls == 0, "R5 align not stalled", last_stalls, 0);
        check(bitptr % 8 == 0, "R5 model aligned", bitptr % 8, 0);
        take(8, 1'b0);
        take(0, 1'b1);
        take(13, 1'b0);
        take(3, 1'b1);
        take(8, 1'b0);

        // R7: idle until full, then input is refused
        repeat (6) @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R7 full refuses", in_ready, 0);
        check(fill_model() <= 64 && fill_model() > 32, "R7 capacity", fill_model(), 64);

        // R4: sustained 32-bit advances never stall
        stall_sum = 0;
        for (int i = 0; i < 16; i++) begin
            take(32, 1'b0);
            stall_sum += last_stalls;
        end
        check(stall_sum == 0, "R4 no stall at full rate", stall_sum, 0);

        // R6: starve the window down to 10 bits, then ask for 24
        feed_en = 1'b0;
        repeat (3) @(negedge clk);
        while (fill_model() > 10) begin
            int n;
            n = fill_model() - 10;
            take((n > 32) ? 32 : n, 1'b0);
        end
        check(fill_model() == 10, "R6 setup", fill_model(), 10);
        fork
            take(24, 1'b0);
            begin
                repeat (4) @(negedge clk);
                #1;
                check(adv_ready == 1'b0, "R6 stalled", adv_ready, 0);
                check(peek_valid == 1'b0, "R8 short buffer", peek_valid, 0);
                check(peek_bits == field_at(bitptr, 24) >> 14 << 14, "R6 nothing consumed",
                      peek_bits, field_at(bitptr, 24) >> 14 << 14);
                feed_en = 1'b1;
            end
        join
        check(last_stalls > 0, "R6 stall seen", last_stalls, 1);
        take(17, 1'b0);
        take(32, 1'b0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all fields seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule